// File: doc/BRIEF.md
# Auxiliary System Control Registers

A small bank of control registers that sits on a simple memory-mapped bus inside a larger chip. Software uses it to hold a configuration byte, a diagnostic byte, a modem-control byte, a 16-bit LED display pattern, a word-wide system-control register and two auxiliary bytes: one for miscellaneous functions and one for software power-down. Several of these registers act on the rest of the system when written. A write to auxiliary-1 sends a one-cycle terminal-count pulse to a floppy controller. A write to auxiliary-2 can request power-off and can clear a sticky power-fail status. A write to system-control can request a whole-system reset.

A single power-fail input loads the sticky status bit in auxiliary-2, and that bit drives an interrupt gated by an enable bit in the configuration register. Each access carries a register select, a byte offset and an access size. The block checks the size and offset against each register and ignores any access that does not match. A reset clears the control registers. It leaves the diagnostic, LED and system-control registers untouched, so software can read after a reset what was there before it.

Top module: `aux_ctl_regs`

## Requirements
- R1: Register select codes are configuration 0, diagnostic 1, modem-control 2, LED 3, system-control 4, auxiliary-1 5 and auxiliary-2 6. Code 7 is unused and reads 0. Size codes are byte 0, halfword 1 and word 2. The five byte registers accept only byte accesses and ignore the offset. The LED register accepts only halfword accesses at offset 0, and system-control accepts only word accesses at offset 0. Any other write is ignored, and any other read returns 0.
- R2: The configuration, diagnostic and modem-control registers store all 8 written bits, and the LED register stores 16. A legal read returns the value zero-extended on `rdata_o` in the same cycle as the request.
- R3: Reset clears the configuration, modem-control, auxiliary-1 and auxiliary-2 registers. It does not alter the diagnostic, LED or system-control registers.
- R4: A legal auxiliary-1 write with bit 1 set raises `fd_tc_o` for exactly the cycle after the write. Bit 1 is never stored and reads 0, while the other seven bits are stored as written.
- R5: An auxiliary-2 write takes only data bits 0 (power-off) and 1 (status clear). Stored bit 5, the power-fail status, is kept from before, and every other stored bit reads 0.
- R6: An auxiliary-2 write with bit 1 set clears the power-fail status and keeps the written bit 0.
- R7: `pwr_off_o` pulses for one cycle, in the cycle after an auxiliary-2 write that stores bit 0 as 1.
- R8: When `pwr_fail_i` changes level, the status bit becomes the new level AND configuration bit 3 (power-interrupt enable). A constant level has no effect. A change takes priority over a status-clear write in the same cycle.
- R9: `irq_o` is high exactly when the status bit and configuration bit 3 are both set. It follows a configuration write, an auxiliary-2 write or an input change at the next clock edge.
- R10: A legal system-control write with bit 0 set loads the value 0x02 and pulses `sys_rst_o` in the cycle after the write. A write with bit 0 clear leaves the value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| sel_i | input | 3 | Register select code |
| off_i | input | 2 | Byte offset inside the selected register |
| size_i | input | 2 | Access size code |
| wdata_i | input | 32 | Write data, right-aligned |
| rdata_o | output | 32 | Read data, combinational, zero-extended |
| pwr_fail_i | input | 1 | Power-fail level from the supply monitor |
| irq_o | output | 1 | Power-fail interrupt |
| fd_tc_o | output | 1 | Terminal-count pulse to the floppy controller |
| pwr_off_o | output | 1 | Power-off request pulse |
| sys_rst_o | output | 1 | System-reset request pulse |

## Verification
Read data is due in the same cycle as the request, so the monitor compares `rdata_o` at the falling edge while the read is still driven. The terminal-count, power-off and system-reset pulses, the status bit and `irq_o` are all due one clock edge after the write or the input change that causes them. Each write therefore queues its expected pulses stamped with the cycle count plus one. In every cycle with no queued item, the monitor also requires all three pulses to be low. Interrupt and status checks are sampled at the first falling edge after that next rising edge, and later reads confirm the retained values.

// File: rtl/aux_ctl_pkg.sv
package aux_ctl_pkg;

  typedef enum logic [2:0] {
    SEL_CFG    = 3'd0,
    SEL_DIAG   = 3'd1,
    SEL_MODEM  = 3'd2,
    SEL_LED    = 3'd3,
    SEL_SYSCTL = 3'd4,
    SEL_AUX1   = 3'd5,
    SEL_AUX2   = 3'd6
  } reg_sel_e;

  localparam int unsigned NUM_SEL = 7;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam int unsigned CFG_PFIE_BIT = 3;
  localparam int unsigned AUX1_TC_BIT  = 1;
  localparam int unsigned AUX2_OFF_BIT = 0;
  localparam int unsigned AUX2_CLR_BIT = 1;
  localparam int unsigned AUX2_PF_BIT  = 5;
  localparam int unsigned SYS_GO_BIT   = 0;
  localparam logic [7:0]  SYS_RST_STAT = 8'h02;

  function automatic acc_size_e sel_size(int unsigned idx);
    case (idx)
      32'(SEL_LED):    return SZ_HALF;
      32'(SEL_SYSCTL): return SZ_WORD;
      default:         return SZ_BYTE;
    endcase
  endfunction

  function automatic bit sel_needs_off0(int unsigned idx);
    return (idx == 32'(SEL_LED)) || (idx == 32'(SEL_SYSCTL));
  endfunction

endpackage

// File: rtl/aux_ctl_store.sv
module aux_ctl_store #(
  parameter int unsigned W          = 8,
  parameter bit          CLR_ON_RST = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] val_q;

  generate
    if (CLR_ON_RST) begin : g_clr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   val_q <= '0;
        else if (we_i) val_q <= d_i;
      end
    end else begin : g_keep
      // survives reset by intent
      logic unused_rst;
      assign unused_rst = rst_ni;
      always_ff @(posedge clk_i) begin
        if (we_i) val_q <= d_i;
      end
    end
  endgenerate

  assign q_o = val_q;

endmodule

// File: rtl/aux_ctl_decode.sv
module aux_ctl_decode
  import aux_ctl_pkg::*;
#(
  parameter int unsigned SEL_W = 3,
  parameter int unsigned OFF_W = 2,
  parameter int unsigned N     = NUM_SEL
) (
  input  logic             req_i,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  output logic [N-1:0]     wr_o,
  output logic [N-1:0]     rd_o
);

  generate
    for (genvar gi = 0; gi < N; gi++) begin : g_sel
      logic hit, size_ok, off_ok;
      assign hit     = req_i && (sel_i == SEL_W'(gi));
      assign size_ok = (size_i == 2'(sel_size(gi)));
      assign off_ok  = !sel_needs_off0(gi) || (off_i == '0);
      assign wr_o[gi] = hit && size_ok && off_ok && we_i;
      assign rd_o[gi] = hit && size_ok && off_ok && !we_i;
    end
  endgenerate

endmodule

// File: rtl/aux_ctl_power.sv
module aux_ctl_power
  import aux_ctl_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              aux1_we_i,
  input  logic              aux2_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              pfie_q_i,   // enable before this edge
  input  logic              pfie_d_i,   // enable after this edge
  input  logic              pwr_fail_i,
  output logic [BYTE_W-1:0] aux1_q_o,
  output logic [BYTE_W-1:0] aux2_q_o,
  output logic              irq_o,
  output logic              tc_o,
  output logic              off_o
);

  localparam logic [BYTE_W-1:0] TC_MASK = BYTE_W'(1) << AUX1_TC_BIT;

  logic              pf_q, pf_evt;
  logic              st_q, st_d;
  logic              off_q, off_d;
  logic              irq_q, tc_q, poff_q;
  logic [BYTE_W-1:0] aux1_q;

  assign pf_evt = pwr_fail_i ^ pf_q;

  always_comb begin
    st_d  = st_q;
    off_d = off_q;
    if (aux2_we_i) begin
      off_d = wdata_i[AUX2_OFF_BIT];
      if (wdata_i[AUX2_CLR_BIT]) st_d = 1'b0;
    end
    // input change outranks a same-cycle clear
    if (pf_evt) st_d = pwr_fail_i & pfie_q_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_q   <= 1'b0;
      st_q   <= 1'b0;
      off_q  <= 1'b0;
      irq_q  <= 1'b0;
      tc_q   <= 1'b0;
      poff_q <= 1'b0;
      aux1_q <= '0;
    end else begin
      pf_q   <= pwr_fail_i;
      st_q   <= st_d;
      off_q  <= off_d;
      irq_q  <= st_d & pfie_d_i;
      tc_q   <= aux1_we_i & wdata_i[AUX1_TC_BIT];
      poff_q <= aux2_we_i & wdata_i[AUX2_OFF_BIT];
      if (aux1_we_i) aux1_q <= wdata_i & ~TC_MASK;
    end
  end

  always_comb begin
    aux2_q_o               = '0;
    aux2_q_o[AUX2_PF_BIT]  = st_q;
    aux2_q_o[AUX2_OFF_BIT] = off_q;
  end

  assign aux1_q_o = aux1_q;
  assign irq_o    = irq_q;
  assign tc_o     = tc_q;
  assign off_o    = poff_q;

endmodule

// File: rtl/aux_ctl_sysctl.sv
module aux_ctl_sysctl
  import aux_ctl_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  output logic [W-1:0] q_o,
  output logic         rst_req_o
);

  logic [W-1:0] val_q;
  logic         req_q;

  // value is kept through reset so software sees why it restarted
  always_ff @(posedge clk_i) begin
    if (go_i) val_q <= W'(SYS_RST_STAT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= go_i;
  end

  assign q_o       = val_q;
  assign rst_req_o = req_q;

endmodule

// File: rtl/aux_ctl_regs.sv
module aux_ctl_regs
  import aux_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned HALF_W = 16,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned OFF_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              pwr_fail_i,
  output logic              irq_o,
  output logic              fd_tc_o,
  output logic              pwr_off_o,
  output logic              sys_rst_o
);

  localparam int unsigned NUM_BYTE_REGS = 3;  // cfg, diag, modem share one shape

  logic [NUM_SEL-1:0] wr, rd;
  logic [BYTE_W-1:0]  byte_q [NUM_BYTE_REGS];
  logic [BYTE_W-1:0]  cfg_q, aux1_q, aux2_q, sysctl_q;
  logic [HALF_W-1:0]  led_q;
  logic               pfie_d;
  logic [DATA_W-1:0]  rd_val [NUM_SEL];

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:HALF_W];

  aux_ctl_decode #(
    .SEL_W(SEL_W),
    .OFF_W(OFF_W),
    .N    (NUM_SEL)
  ) u_decode (
    .req_i (req_i),
    .we_i  (we_i),
    .sel_i (sel_i),
    .off_i (off_i),
    .size_i(size_i),
    .wr_o  (wr),
    .rd_o  (rd)
  );

  generate
    for (genvar gi = 0; gi < NUM_BYTE_REGS; gi++) begin : g_byte
      aux_ctl_store #(
        .W         (BYTE_W),
        .CLR_ON_RST(gi != int'(SEL_DIAG))
      ) u_reg (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .we_i  (wr[gi]),
        .d_i   (wdata_i[BYTE_W-1:0]),
        .q_o   (byte_q[gi])
      );
    end
  endgenerate

  assign cfg_q = byte_q[SEL_CFG];

  aux_ctl_store #(
    .W         (HALF_W),
    .CLR_ON_RST(1'b0)
  ) u_led (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (wr[SEL_LED]),
    .d_i   (wdata_i[HALF_W-1:0]),
    .q_o   (led_q)
  );

  assign pfie_d = wr[SEL_CFG] ? wdata_i[CFG_PFIE_BIT] : cfg_q[CFG_PFIE_BIT];

  aux_ctl_power #(
    .BYTE_W(BYTE_W)
  ) u_power (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .aux1_we_i (wr[SEL_AUX1]),
    .aux2_we_i (wr[SEL_AUX2]),
    .wdata_i   (wdata_i[BYTE_W-1:0]),
    .pfie_q_i  (cfg_q[CFG_PFIE_BIT]),
    .pfie_d_i  (pfie_d),
    .pwr_fail_i(pwr_fail_i),
    .aux1_q_o  (aux1_q),
    .aux2_q_o  (aux2_q),
    .irq_o     (irq_o),
    .tc_o      (fd_tc_o),
    .off_o     (pwr_off_o)
  );

  aux_ctl_sysctl #(
    .W(BYTE_W)
  ) u_sysctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (wr[SEL_SYSCTL] & wdata_i[SYS_GO_BIT]),
    .q_o      (sysctl_q),
    .rst_req_o(sys_rst_o)
  );

  assign rd_val[SEL_CFG]    = DATA_W'(cfg_q);
  assign rd_val[SEL_DIAG]   = DATA_W'(byte_q[SEL_DIAG]);
  assign rd_val[SEL_MODEM]  = DATA_W'(byte_q[SEL_MODEM]);
  assign rd_val[SEL_LED]    = DATA_W'(led_q);
  assign rd_val[SEL_SYSCTL] = DATA_W'(sysctl_q);
  assign rd_val[SEL_AUX1]   = DATA_W'(aux1_q);
  assign rd_val[SEL_AUX2]   = DATA_W'(aux2_q);

  // one-hot strobes, so an OR-mux suffices
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_SEL; i++) begin
      if (rd[i]) rdata_o = rdata_o | rd_val[i];
    end
  end

endmodule

// File: rtl/aux_ctl_regs_chk.sv
module aux_ctl_regs_chk
  import aux_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned OFF_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [SEL_W-1:0]  sel_i,
  input logic [OFF_W-1:0]  off_i,
  input logic [1:0]        size_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              pwr_fail_i,
  input logic              irq_o,
  input logic              fd_tc_o,
  input logic              pwr_off_o,
  input logic              sys_rst_o,
  input logic [BYTE_W-1:0] cfg_q,
  input logic [BYTE_W-1:0] aux1_q,
  input logic [BYTE_W-1:0] aux2_q,
  input logic [BYTE_W-1:0] sysctl_q
);

  localparam logic [BYTE_W-1:0] AUX2_LIVE =
    (BYTE_W'(1) << AUX2_PF_BIT) | (BYTE_W'(1) << AUX2_OFF_BIT);

  logic aux1_wr, aux2_wr, cfg_bad_wr, sys_go;

  assign aux1_wr    = req_i && we_i && (sel_i == SEL_AUX1) && (size_i == SZ_BYTE);
  assign aux2_wr    = req_i && we_i && (sel_i == SEL_AUX2) && (size_i == SZ_BYTE);
  assign cfg_bad_wr = req_i && we_i && (sel_i == SEL_CFG) && (size_i != SZ_BYTE);
  assign sys_go     = req_i && we_i && (sel_i == SEL_SYSCTL) && (size_i == SZ_WORD)
                      && (off_i == '0) && wdata_i[SYS_GO_BIT];

  assert_cfg_size_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_bad_wr |=> $stable(cfg_q));

  assert_tc_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux1_wr && wdata_i[AUX1_TC_BIT]) |=> fd_tc_o);

  assert_tc_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(aux1_wr && wdata_i[AUX1_TC_BIT]) |=> !fd_tc_o);

  assert_tc_unstored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aux1_q[AUX1_TC_BIT]);

  assert_aux2_fields_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux2_q & ~AUX2_LIVE) == '0);

  assert_status_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux2_wr && wdata_i[AUX2_CLR_BIT] && (pwr_fail_i == $past(pwr_fail_i)))
      |=> !aux2_q[AUX2_PF_BIT]);

  assert_pwroff_stored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_off_o |-> aux2_q[AUX2_OFF_BIT]);

  assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (aux2_q[AUX2_PF_BIT] && cfg_q[CFG_PFIE_BIT]));

  assert_sysrst_go_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_go |=> sys_rst_o);

  assert_sysrst_value_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> (sysctl_q == BYTE_W'(SYS_RST_STAT)));

endmodule

bind aux_ctl_regs aux_ctl_regs_chk #(
  .DATA_W(DATA_W),
  .BYTE_W(BYTE_W),
  .SEL_W (SEL_W),
  .OFF_W (OFF_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .sel_i     (sel_i),
  .off_i     (off_i),
  .size_i    (size_i),
  .wdata_i   (wdata_i),
  .pwr_fail_i(pwr_fail_i),
  .irq_o     (irq_o),
  .fd_tc_o   (fd_tc_o),
  .pwr_off_o (pwr_off_o),
  .sys_rst_o (sys_rst_o),
  .cfg_q     (cfg_q),
  .aux1_q    (aux1_q),
  .aux2_q    (aux2_q),
  .sysctl_q  (sysctl_q)
);

// File: tb/aux_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module aux_ctl_regs_tb_top;
  import aux_ctl_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [2:0]  sel_i = '0;
  logic [1:0]  off_i = '0, size_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        pwr_fail_i = 1'b0;
  logic        irq_o, fd_tc_o, pwr_off_o, sys_rst_o;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } rd_item_t;
  typedef struct { int cyc; logic tc; logic off; logic rst; string tag; } pl_item_t;
  rd_item_t rq[$];
  pl_item_t pq[$];

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  aux_ctl_regs dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .sel_i(sel_i),
    .off_i(off_i), .size_i(size_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pwr_fail_i(pwr_fail_i), .irq_o(irq_o), .fd_tc_o(fd_tc_o),
    .pwr_off_o(pwr_off_o), .sys_rst_o(sys_rst_o)
  );

  // monitor: compares against queued expectations away from the active edge
  always @(negedge clk_i) begin
    rd_item_t r;
    pl_item_t p;
    if (rst_ni && req_i && !we_i) begin
      checks++;
      if (rq.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected read: actual %h expected none", rdata_o);
      end else begin
        r = rq.pop_front();
        if (rdata_o !== r.exp) begin
          fails++;
          $display("FAIL %s: rdata actual %h expected %h", r.tag, rdata_o, r.exp);
        end
      end
    end
    if (pq.size() > 0 && pq[0].cyc == cyc) begin
      p = pq.pop_front();
      checks++;
      if ({fd_tc_o, pwr_off_o, sys_rst_o} !== {p.tc, p.off, p.rst}) begin
        fails++;
        $display("FAIL %s: pulses tc/off/rst actual %b%b%b expected %b%b%b",
                 p.tag, fd_tc_o, pwr_off_o, sys_rst_o, p.tc, p.off, p.rst);
      end
    end else if (fd_tc_o || pwr_off_o || sys_rst_o) begin
      checks++;
      fails++;
      $display("FAIL R4/R7/R10 stray pulse: actual %b%b%b expected 000",
               fd_tc_o, pwr_off_o, sys_rst_o);
    end
  end

  task automatic acc(input logic we, input logic [2:0] sel, input logic [1:0] off,
                     input logic [1:0] sz, input logic [31:0] d, input int pf);
    @(posedge clk_i); #1;
    req_i = 1'b1; we_i = we; sel_i = sel; off_i = off; size_i = sz; wdata_i = d;
    if (pf >= 0) pwr_fail_i = pf[0];
    @(posedge clk_i); #1;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [1:0] off, input logic [1:0] sz,
                    input logic [31:0] d, input logic etc, input logic eoff,
                    input logic erst, input string tag, input int pf = -1);
    pl_item_t p;
    acc(1'b1, sel, off, sz, d, pf);
    p.cyc = cyc; p.tc = etc; p.off = eoff; p.rst = erst; p.tag = tag;
    pq.push_back(p);
  endtask

  task automatic rd(input logic [2:0] sel, input logic [1:0] off, input logic [1:0] sz,
                    input logic [31:0] exp, input string tag);
    rd_item_t r;
    r.exp = exp; r.tag = tag;
    rq.push_back(r);
    acc(1'b0, sel, off, sz, 32'h0, -1);
  endtask

  task automatic set_pf(input logic v);
    @(posedge clk_i); #1;
    pwr_fail_i = v;
    @(posedge clk_i); #1;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk_i);
    checks++;
    if (irq_o !== exp) begin
      fails++;
      $display("FAIL %s: irq actual %b expected %b", tag, irq_o, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R3 reset state
    rd(SEL_CFG,   0, SZ_BYTE, 32'h0, "R3 cfg after reset");
    rd(SEL_MODEM, 0, SZ_BYTE, 32'h0, "R3 modem after reset");
    rd(SEL_AUX1,  0, SZ_BYTE, 32'h0, "R3 aux1 after reset");
    rd(SEL_AUX2,  0, SZ_BYTE, 32'h0, "R3 aux2 after reset");
    chk_irq(1'b0, "R9 irq after reset");

    // R2 plain storage
    wr(SEL_DIAG,  0, SZ_BYTE, 32'hA5,   0, 0, 0, "R2 diag write");
    wr(SEL_MODEM, 0, SZ_BYTE, 32'h3C,   0, 0, 0, "R2 modem write");
    wr(SEL_LED,   0, SZ_HALF, 32'hBEEF, 0, 0, 0, "R2 led write");
    wr(SEL_CFG,   0, SZ_BYTE, 32'h5A,   0, 0, 0, "R2 cfg write");
    rd(SEL_DIAG,  0, SZ_BYTE, 32'hA5,   "R2 diag read");
    rd(SEL_MODEM, 0, SZ_BYTE, 32'h3C,   "R2 modem read");
    rd(SEL_LED,   0, SZ_HALF, 32'hBEEF, "R2 led read");
    rd(SEL_CFG,   0, SZ_BYTE, 32'h5A,   "R2 cfg read");
    chk_irq(1'b0, "R9 enable without status");

    // R1 size and offset legality
    wr(SEL_LED, 0, SZ_BYTE, 32'h1234, 0, 0, 0, "R1 led byte write");
    rd(SEL_LED, 0, SZ_HALF, 32'hBEEF, "R1 led byte write ignored");
    wr(SEL_LED, 2, SZ_HALF, 32'h1111, 0, 0, 0, "R1 led offset write");
    rd(SEL_LED, 0, SZ_HALF, 32'hBEEF, "R1 led offset write ignored");
    rd(SEL_LED, 0, SZ_BYTE, 32'h0,    "R1 led byte read");
    rd(SEL_CFG, 0, SZ_WORD, 32'h0,    "R1 cfg word read");
    wr(SEL_CFG, 0, SZ_HALF, 32'h00,   0, 0, 0, "R1 cfg half write");
    rd(SEL_CFG, 0, SZ_BYTE, 32'h5A,   "R1 cfg half write ignored");
    rd(3'd7,    0, SZ_BYTE, 32'h0,    "R1 unused select");
    wr(SEL_DIAG, 3, SZ_BYTE, 32'h77,  0, 0, 0, "R1 diag offset write");
    rd(SEL_DIAG, 1, SZ_BYTE, 32'h77,  "R1 byte offset ignored");
    wr(SEL_CFG, 0, SZ_BYTE, 32'h00,   0, 0, 0, "R2 cfg clear");

    // R4 terminal count
    wr(SEL_AUX1, 0, SZ_BYTE, 32'hFF, 1, 0, 0, "R4 tc pulse");
    rd(SEL_AUX1, 0, SZ_BYTE, 32'hFD, "R4 tc bit not stored");
    wr(SEL_AUX1, 0, SZ_BYTE, 32'h40, 0, 0, 0, "R4 no tc");
    rd(SEL_AUX1, 0, SZ_BYTE, 32'h40, "R4 other bits stored");
    wr(SEL_AUX1, 0, SZ_HALF, 32'h02, 0, 0, 0, "R1 aux1 half write no tc");
    rd(SEL_AUX1, 0, SZ_BYTE, 32'h40, "R1 aux1 half write ignored");

    // R8 / R9 power-fail status and interrupt
    set_pf(1'b1);
    rd(SEL_AUX2, 0, SZ_BYTE, 32'h00, "R8 fail with enable off");
    chk_irq(1'b0, "R9 enable off");
    set_pf(1'b0);
    wr(SEL_CFG, 0, SZ_BYTE, 32'h08, 0, 0, 0, "R9 enable on");
    chk_irq(1'b0, "R9 enable without status");
    set_pf(1'b1);
    chk_irq(1'b1, "R9 irq on fail");
    rd(SEL_AUX2, 0, SZ_BYTE, 32'h20, "R8 status set");
    wr(SEL_CFG, 0, SZ_BYTE, 32'h00, 0, 0, 0, "R9 disable");
    chk_irq(1'b0, "R9 irq gated off");
    rd(SEL_AUX2, 0, SZ_BYTE, 32'h20, "R8 status sticky across gate");
    wr(SEL_CFG, 0, SZ_BYTE, 32'h08, 0, 0, 0, "R9 re-enable");
    chk_irq(1'b1, "R9 irq gated on");

    // R5 / R6 auxiliary-2 writes
    wr(SEL_AUX2, 0, SZ_BYTE, 32'h00, 0, 0, 0, "R5 aux2 zero write");
    rd(SEL_AUX2, 0, SZ_BYTE, 32'h20, "R5 status merged");
    wr(SEL_AUX2, 0, SZ_BYTE, 32'hFC, 0, 0, 0, "R5 aux2 masked write");
    rd(SEL_AUX2, 0, SZ_BYTE, 32'h20, "R5 other bits dropped");
    chk_irq(1'b1, "R9 irq held");
    wr(SEL_AUX2, 0, SZ_BYTE, 32'hDE, 0, 0, 0, "R6 clear write");
    chk_irq(1'b0, "R6 irq after clear");
    rd(SEL_AUX2, 0, SZ_BYTE, 32'h00, "R6 status cleared");
    repeat (3) @(posedge clk_i);
    rd(SEL_AUX2, 0, SZ_BYTE, 32'h00, "R8 steady level no effect");
    set_pf(1'b0);
    rd(SEL_AUX2, 0, SZ_BYTE, 32'h00, "R8 fall keeps clear");
    set_pf(1'b1);
    rd(SEL_AUX2, 0, SZ_BYTE, 32'h20, "R8 rise sets status");
    wr(SEL_AUX2, 0, SZ_BYTE, 32'h03, 0, 1, 0, "R7 power-off with clear");
    chk_irq(1'b0, "R6 irq after clear with off");
    rd(SEL_AUX2, 0, SZ_BYTE, 32'h01, "R6 bit0 kept on clear");
    set_pf(1'b0);
    rd(SEL_AUX2, 0, SZ_BYTE, 32'h01, "R8 fall on clear status");
    set_pf(1'b1);
    rd(SEL_AUX2, 0, SZ_BYTE, 32'h21, "R8 rise with off stored");
    set_pf(1'b0);
    chk_irq(1'b0, "R8 fall clears irq");
    rd(SEL_AUX2, 0, SZ_BYTE, 32'h01, "R8 fall clears status");

    // R7 power-off request
    wr(SEL_AUX2, 0, SZ_BYTE, 32'h00, 0, 0, 0, "R7 no power-off");
    rd(SEL_AUX2, 0, SZ_BYTE, 32'h00, "R7 off bit cleared");
    wr(SEL_AUX2, 0, SZ_BYTE, 32'h21, 0, 1, 0, "R7 power-off pulse");
    rd(SEL_AUX2, 0, SZ_BYTE, 32'h01, "R5 bit5 of data not taken");
    wr(SEL_AUX2, 0, SZ_WORD, 32'h00, 0, 0, 0, "R1 aux2 word write");
    rd(SEL_AUX2, 0, SZ_BYTE, 32'h01, "R1 aux2 word write ignored");

    // R8 priority over same-cycle clear
    wr(SEL_AUX2, 0, SZ_BYTE, 32'h02, 0, 0, 0, "R8 clear with rising input", 1);
    chk_irq(1'b1, "R8 input wins irq");
    rd(SEL_AUX2, 0, SZ_BYTE, 32'h20, "R8 input wins status");
    wr(SEL_AUX2, 0, SZ_BYTE, 32'h02, 0, 0, 0, "R6 clear at steady input");
    rd(SEL_AUX2, 0, SZ_BYTE, 32'h00, "R6 clear at steady input");
    set_pf(1'b0);

    // R10 system control
    wr(SEL_SYSCTL, 1, SZ_WORD, 32'h1, 0, 0, 0, "R10 offset write ignored");
    wr(SEL_SYSCTL, 0, SZ_BYTE, 32'h1, 0, 0, 0, "R10 byte write ignored");
    wr(SEL_SYSCTL, 0, SZ_WORD, 32'h1, 0, 0, 1, "R10 reset request");
    rd(SEL_SYSCTL, 0, SZ_WORD, 32'h02, "R10 reset status");
    rd(SEL_SYSCTL, 1, SZ_WORD, 32'h0,  "R1 sysctl offset read");
    wr(SEL_SYSCTL, 0, SZ_WORD, 32'hFFFF_FFFE, 0, 0, 0, "R10 bit0 clear write");
    rd(SEL_SYSCTL, 0, SZ_WORD, 32'h02, "R10 value unchanged");

    // R3 retention across reset
    wr(SEL_AUX1, 0, SZ_BYTE, 32'h10, 0, 0, 0, "R3 aux1 preset");
    wr(SEL_AUX2, 0, SZ_BYTE, 32'h01, 0, 1, 0, "R3 aux2 preset");
    do_reset();
    rd(SEL_CFG,    0, SZ_BYTE, 32'h0,    "R3 cfg cleared");
    rd(SEL_MODEM,  0, SZ_BYTE, 32'h0,    "R3 modem cleared");
    rd(SEL_AUX1,   0, SZ_BYTE, 32'h0,    "R3 aux1 cleared");
    rd(SEL_AUX2,   0, SZ_BYTE, 32'h0,    "R3 aux2 cleared");
    rd(SEL_DIAG,   0, SZ_BYTE, 32'h77,   "R3 diag kept");
    rd(SEL_LED,    0, SZ_HALF, 32'hBEEF, "R3 led kept");
    rd(SEL_SYSCTL, 0, SZ_WORD, 32'h02,   "R3 sysctl kept");
    chk_irq(1'b0, "R3 irq after second reset");

    repeat (3) @(posedge clk_i);
    if (rq.size() != 0 || pq.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL R2/R4 queue not drained: actual %0d/%0d expected 0/0",
               rq.size(), pq.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule